// File: doc/BRIEF.md
# Event Interrupt Status and Mask Unit

This unit collects the event conditions of a serial peripheral and turns them into a single level interrupt. Seven event sources are latched into a sticky status register. Software clears status bits by writing ones to that register, so writing back a value it has just read clears exactly the bits it saw. Which bits may raise the interrupt is held in a mask. The mask is changed only through two write-only ports, one that sets bits and one that clears them, and it is read back through a separate read-only register.

One of the sources, the transmit low-level event, is formed inside the unit. It compares the transmit queue occupancy, supplied as an input, against a programmable watermark register. The queues and the shift engine stay outside the unit and present their conditions as inputs. Register reads are combinational from the addressed register. Writes take effect at the clock edge.

Top module: `evirq_top`

## Requirements
- R1: The status register reads at byte offset 0x04 with this bit layout: bit 0 aux0, bit 1 mode fault, bit 2 transmit low-level, bit 3 transmit full, bit 4 receive not-empty, bit 5 aux1, bit 6 aux2. A bit becomes 1 at the clock edge after a cycle in which its source is high, and it stays 1 until it is cleared.
- R2: A write to 0x04 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R3: If a source is high in the same cycle that a write to 0x04 clears its bit, the bit is 1 after the edge.
- R4: A write to 0x08 sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R5: A write to 0x0C clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 are unchanged.
- R6: The mask reads at 0x10, using the same bit layout as R1. Reads of 0x08 and 0x0C return 0.
- R7: irq_o equals the OR of status AND mask, delayed by one register.
- R8: The watermark register reads and writes at 0x28 and resets to 1. The transmit low-level source is high while tx_level_i is below the watermark.
- R9: After reset, status, mask and irq_o are all 0.
- R10: Reads of any other offset return 0. Read data bits above bit 6 are 0 at 0x04 and 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 6 | Read byte offset |
| rd_data_o | output | 32 | Read data, combinational |
| fault_i | input | 1 | Mode fault condition |
| tx_full_i | input | 1 | Transmit queue full condition |
| rx_nempty_i | input | 1 | Receive queue not-empty condition |
| aux_i | input | 3 | Auxiliary conditions for bits 0, 5 and 6 |
| tx_level_i | input | 8 | Transmit queue occupancy |
| irq_o | output | 1 | Level interrupt |

## Verification
The critical overlap is a source event arriving in the same cycle as a write-one-to-clear of the same status bit. The bench produces it by holding the receive not-empty and mode fault inputs high while it writes a clear of those bits. It also produces it by running random source patterns alongside random clear writes. A behavioural reference model, updated at every edge, decides that the set wins. Read data and irq_o are compared with that model on every cycle, so any cycle in which a collision drops a bit is reported.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
    localparam int NUM_SRC = 7;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int LVL_W   = 8;

    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_SETM = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CLRM = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_WMRK = 6'h28;

    // bit positions shared by status and mask
    localparam int B_AUX0  = 0;
    localparam int B_FAULT = 1;
    localparam int B_TXLOW = 2;
    localparam int B_TXFUL = 3;
    localparam int B_RXNE  = 4;
    localparam int B_AUX1  = 5;
    localparam int B_AUX2  = 6;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STAT, SEL_SETM, SEL_CLRM, SEL_MASK, SEL_WMRK
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] stat_clr;
        logic [NUM_SRC-1:0] mask_set;
        logic [NUM_SRC-1:0] mask_clr;
        logic               wm_we;
        logic [LVL_W-1:0]   wm_val;
    } wr_cmd_t;

    function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STAT: decode = SEL_STAT;
            OFS_SETM: decode = SEL_SETM;
            OFS_CLRM: decode = SEL_CLRM;
            OFS_MASK: decode = SEL_MASK;
            OFS_WMRK: decode = SEL_WMRK;
            default:  decode = SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/evirq_wmark.sv
module evirq_wmark
    import evirq_pkg::*;
#(
    parameter int LW = LVL_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [LW-1:0] wdata,
    input  logic [LW-1:0] level,
    output logic [LW-1:0] wm_q,
    output logic          low
);
    localparam logic [LW-1:0] WM_RST = LW'(1);

    always_ff @(posedge clk) begin
        if (rst)     wm_q <= WM_RST;
        else if (we) wm_q <= wdata;
    end

    assign low = (level < wm_q);

    assert_wm_reset_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wm_q == WM_RST));
    assert_wm_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(wm_q));
endmodule

// File: rtl/evirq_status.sv
module evirq_status
    import evirq_pkg::*;
#(
    parameter int N = NUM_SRC
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev_set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)            stat_q[i] <= 1'b0;
            else if (ev_set[i]) stat_q[i] <= 1'b1;
            else if (clr[i])    stat_q[i] <= 1'b0;
        end
    end

    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_set != '0) |=> ((stat_q & $past(ev_set)) == $past(ev_set)));
    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~ev_set) != '0) |=> ((stat_q & $past(clr & ~ev_set)) == '0));
    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/evirq_mask.sv
module evirq_mask
    import evirq_pkg::*;
#(
    parameter int N = NUM_SRC
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= (mask_q | set_bits) & ~clr_bits;
    end

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
        (set_bits != '0) |=> ((mask_q & $past(set_bits)) == $past(set_bits)));
    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_bits != '0) |=> ((mask_q & $past(clr_bits)) == '0));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (set_bits == '0 && clr_bits == '0) |=> $stable(mask_q));
endmodule

// File: rtl/evirq_top.sv
module evirq_top
    import evirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              fault_i,
    input  logic              tx_full_i,
    input  logic              rx_nempty_i,
    input  logic [2:0]        aux_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    output logic              irq_o
);
    wr_cmd_t            cmd;
    reg_sel_e           wsel, rsel;
    logic [NUM_SRC-1:0] ev, stat, mask;
    logic [LVL_W-1:0]   wm;
    logic               tx_low;

    always_comb begin
        wsel = wr_en_i ? decode(wr_addr_i) : SEL_NONE;
        cmd  = '0;
        case (wsel)
            SEL_STAT: cmd.stat_clr = wr_data_i[NUM_SRC-1:0];
            SEL_SETM: cmd.mask_set = wr_data_i[NUM_SRC-1:0];
            SEL_CLRM: cmd.mask_clr = wr_data_i[NUM_SRC-1:0];
            SEL_WMRK: begin
                cmd.wm_we  = 1'b1;
                cmd.wm_val = wr_data_i[LVL_W-1:0];
            end
            default: ;
        endcase
    end

    evirq_wmark u_wm (
        .clk(clk), .rst(rst), .we(cmd.wm_we), .wdata(cmd.wm_val),
        .level(tx_level_i), .wm_q(wm), .low(tx_low)
    );

    always_comb begin
        ev          = '0;
        ev[B_AUX0]  = aux_i[0];
        ev[B_FAULT] = fault_i;
        ev[B_TXLOW] = tx_low;
        ev[B_TXFUL] = tx_full_i;
        ev[B_RXNE]  = rx_nempty_i;
        ev[B_AUX1]  = aux_i[1];
        ev[B_AUX2]  = aux_i[2];
    end

    evirq_status u_st (
        .clk(clk), .rst(rst), .ev_set(ev), .clr(cmd.stat_clr), .stat_q(stat)
    );

    evirq_mask u_mk (
        .clk(clk), .rst(rst), .set_bits(cmd.mask_set),
        .clr_bits(cmd.mask_clr), .mask_q(mask)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(stat & mask);
    end

    always_comb begin
        rsel      = decode(rd_addr_i);
        rd_data_o = '0;
        case (rsel)
            SEL_STAT: rd_data_o = DATA_W'(stat);
            SEL_MASK: rd_data_o = DATA_W'(mask);
            SEL_WMRK: rd_data_o = DATA_W'(wm);
            default:  rd_data_o = '0;
        endcase
    end

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == |$past(stat & mask)));
    assert_irq_reset_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && stat == '0 && mask == '0));
    assert_wo_read_R6: assert property (@(posedge clk) disable iff (rst)
        (rsel == SEL_SETM || rsel == SEL_CLRM) |-> (rd_data_o == '0));
endmodule

// File: tb/sim_evirq_top.sv
module sim_evirq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = 6'h04;
    logic [31:0] rd_data;
    logic        fault = 0, txful = 0, rxne = 0;
    logic [2:0]  aux = '0;
    logic [7:0]  lvl = 8'd4;
    logic        irq;

    int errors = 0, checks = 0, cyc = 0;
    logic [6:0] m_stat = '0, m_mask = '0;
    logic [7:0] m_wm = 8'd1;
    logic       m_irq = 1'b0;

    always #2 clk = ~clk;

    evirq_top u0 (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .fault_i(fault), .tx_full_i(txful), .rx_nempty_i(rxne), .aux_i(aux),
        .tx_level_i(lvl), .irq_o(irq)
    );

    // behavioural reference, updated on each edge
    always @(posedge clk) begin
        logic [6:0] ev, clr;
        logic       nirq;
        if (rst) begin
            m_stat = '0; m_mask = '0; m_wm = 8'd1; m_irq = 1'b0;
        end else begin
            nirq = (m_stat & m_mask) != 0;
            ev  = {aux[2], aux[1], rxne, txful, (lvl < m_wm), fault, aux[0]};
            clr = (wr_en && wr_addr == 6'h04) ? wr_data[6:0] : 7'd0;
            m_stat = (m_stat & ~clr) | ev;
            if (wr_en && wr_addr == 6'h08) m_mask = m_mask | wr_data[6:0];
            if (wr_en && wr_addr == 6'h0C) m_mask = m_mask & ~wr_data[6:0];
            if (wr_en && wr_addr == 6'h28) m_wm = wr_data[7:0];
            m_irq = nirq;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        logic [31:0] exp;
        string       tag;
        cyc++;
        exp = '0;
        case (rd_addr)
            6'h04: begin exp = {25'd0, m_stat}; tag = "R1/R2/R3"; end
            6'h10: begin exp = {25'd0, m_mask}; tag = "R6/R4/R5"; end
            6'h08, 6'h0C: tag = "R6 write-only read";
            6'h28: begin exp = {24'd0, m_wm}; tag = "R8"; end
            default: tag = "R10";
        endcase
        if (rst) tag = "R9";
        chk(rd_data === exp, tag, rd_data, exp);
        chk(irq === m_irq, rst ? "R9 irq" : "R7 irq", {31'd0, irq}, {31'd0, m_irq});
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: reset state at every readable offset
        for (int i = 0; i < 6; i++) begin
            rd_addr = (i == 0) ? 6'h04 : (i == 1) ? 6'h10 : (i == 2) ? 6'h28 :
                      (i == 3) ? 6'h08 : (i == 4) ? 6'h0C : 6'h14;
            step(1);
        end
        rst = 0;
        rd_addr = 6'h04;
        step(2);
        // R1: each source alone, bit layout
        fault = 1; step(1); fault = 0;
        txful = 1; step(1); txful = 0;
        rxne = 1;  step(1); rxne = 0;
        aux = 3'b101; step(1); aux = 0;
        step(2);
        // R2: write back what was read, then zero bits untouched
        wr(6'h04, 32'h0000_0002);
        wr(6'h04, 32'hFFFF_FF7F);
        // R8: reset watermark, level 0 raises bit 2
        rd_addr = 6'h28; step(1);
        lvl = 0; rd_addr = 6'h04; step(2); lvl = 4;
        wr(6'h28, 32'd5); rd_addr = 6'h28; step(1);
        lvl = 8'd3; rd_addr = 6'h04; step(2);
        wr(6'h04, 32'h7F); step(1);
        lvl = 8'd5; step(1);
        wr(6'h04, 32'h7F); step(2);
        lvl = 8'd6; step(2);
        // R4/R5/R6/R7: mask set/clear, zero bits have no effect
        rxne = 1; step(1); rxne = 0;
        rd_addr = 6'h10;
        wr(6'h08, 32'h10); step(2);
        wr(6'h08, 32'h00); step(1);
        rd_addr = 6'h08; step(1); rd_addr = 6'h0C; step(1); rd_addr = 6'h10;
        wr(6'h0C, 32'h00); step(1);
        wr(6'h0C, 32'h10); step(2);
        wr(6'h08, 32'h7F); step(1);
        // R3: clear collides with live source
        rd_addr = 6'h04;
        rxne = 1; fault = 1;
        wr(6'h04, 32'h7F);
        rxne = 0; fault = 0; step(2);
        wr(6'h04, 32'h7F); step(2);
        // R10: other offsets read zero
        rd_addr = 6'h00; step(1); rd_addr = 6'h3C; step(1);
        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            @(negedge clk); #1;
            fault = ($urandom % 8) == 0;
            txful = ($urandom % 6) == 0;
            rxne  = ($urandom % 5) == 0;
            aux   = (($urandom % 4) == 0) ? 3'($urandom) : 3'd0;
            lvl   = 8'($urandom % 8);
            case ($urandom % 6)
                0: rd_addr = 6'h04; 1: rd_addr = 6'h10; 2: rd_addr = 6'h28;
                3: rd_addr = 6'h08; 4: rd_addr = 6'h0C; default: rd_addr = 6'h18;
            endcase
            wr_en = ($urandom % 3) == 0;
            case ($urandom % 5)
                0: wr_addr = 6'h04; 1: wr_addr = 6'h08; 2: wr_addr = 6'h0C;
                3: wr_addr = 6'h28; default: wr_addr = 6'h14;
            endcase
            wr_data = (wr_addr == 6'h28) ? 32'($urandom % 7) : $urandom;
        end
        @(negedge clk); #1; wr_en = 0;
        step(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule